// File: doc/BRIEF.md
# Six-Read Store Unlock Detector

This block watches the stream of completed memory accesses on a byte-wide memory port and looks for a fixed unlock code. The code is six reads, and they must arrive in a fixed order to six fixed addresses. Each access is shown to the detector as a one-cycle strobe, together with its address and a write flag. Only accesses that the chip enable completes produce a strobe. The output-enable level plays no part, so a read counts whether or not its data was driven out.

When the sixth read arrives after the other five, the detector raises a one-cycle store request. Any write stops a partly matched code, and so does any read to the wrong address. While the store engine reports that it is busy, the detector holds its progress at zero and ignores every strobe. This keeps accesses made during a transfer from counting toward a new code.

Top module: `unlock_detector`

## Requirements
- R1: After a synchronous reset, `store_req` is 0 and all progress is cleared. A reset in the middle of the code means all six reads are needed again.
- R2: Six read strobes (`acc_stb`=1, `acc_wr`=0) to 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0, in that order, make `store_req` 1 for exactly one cycle. That cycle is the one after the clock edge that samples the sixth strobe.
- R3: Cycles with `acc_stb`=0 neither advance the code nor break it, however many there are between steps.
- R4: A strobe with `acc_wr`=1 at any step aborts the code, even when its address is the one expected. Such a strobe never counts as a step.
- R5: A read to an address other than the expected one aborts the code, and the remaining reads then give no request.
- R6: A read of 0x0E38 that breaks the code is taken as step one of a fresh attempt. The five remaining reads then complete it.
- R7: While `busy`=1, progress is held at zero and strobes are ignored, so `store_req` stays 0. After `busy` falls, a full six-read code is needed.
- R8: After a request, progress is zero. Reads of steps two to six alone give no further request.
- R9: The order is enforced: the same six addresses in any other order give no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Store transfer in progress; clears and freezes the detector |
| acc_stb | input | 1 | One-cycle strobe per completed chip-enable access |
| acc_wr | input | 1 | 1 when the strobed access is a write |
| acc_addr | input | ADDR_W | Address of the strobed access |
| store_req | output | 1 | One-cycle store request pulse |

## Verification
The bench builds the detector with its default 15-bit address width. At that width the six code addresses and the near-miss address are all exact port values, so every step and every abort path can be reached directly. Running complete codes back to back, and codes split by idle gaps, exercises the counter's wrap after a request. It also exercises the hold behaviour that a gap-free stream never reaches.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

    localparam int SEQ_LEN    = 6;
    localparam int CODE_W     = 15;
    localparam int STEP_W     = $clog2(SEQ_LEN);

    // Address expected at each position of the unlock code.
    function automatic logic [CODE_W-1:0] code_addr(input int idx);
        case (idx)
            0:       code_addr = 15'h0E38;
            1:       code_addr = 15'h31C7;
            2:       code_addr = 15'h03E0;
            3:       code_addr = 15'h3C1F;
            4:       code_addr = 15'h303F;
            default: code_addr = 15'h0FC0;
        endcase
    endfunction

    typedef enum logic [2:0] {
        EV_HOLD,
        EV_CLEAR,
        EV_ABORT,
        EV_ADVANCE,
        EV_RESTART,
        EV_FIRE
    } unlock_ev_e;

    typedef struct packed {
        logic hit_step;
        logic hit_first;
        logic at_last;
    } match_t;

endpackage

// File: rtl/unlock_addr_match.sv
module unlock_addr_match
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [STEP_W-1:0] step,
    output match_t            match
);

    localparam int EXT_W = (ADDR_W > CODE_W) ? ADDR_W : CODE_W;

    logic [SEQ_LEN-1:0] hit_vec;
    logic [SEQ_LEN-1:0] sel_vec;
    logic [EXT_W-1:0]   addr_ext;

    assign addr_ext = EXT_W'(addr);

    for (genvar i = 0; i < SEQ_LEN; i++) begin : g_cmp
        assign hit_vec[i] = (addr_ext == EXT_W'(code_addr(i)));
        assign sel_vec[i] = (step == STEP_W'(i));
    end

    always_comb begin
        match.hit_step  = |(hit_vec & sel_vec);
        match.hit_first = hit_vec[0];
        match.at_last   = sel_vec[SEQ_LEN-1];
    end

endmodule

// File: rtl/unlock_event_classify.sv
module unlock_event_classify
    import unlock_seq_pkg::*;
(
    input  logic       busy,
    input  logic       stb,
    input  logic       wr,
    input  match_t     match,
    output unlock_ev_e ev
);

    always_comb begin
        if (busy)                                  ev = EV_CLEAR;
        else if (!stb)                             ev = EV_HOLD;
        else if (wr)                               ev = EV_ABORT;
        else if (match.hit_step && match.at_last)  ev = EV_FIRE;
        else if (match.hit_step)                   ev = EV_ADVANCE;
        else if (match.hit_first)                  ev = EV_RESTART;
        else                                       ev = EV_ABORT;
    end

endmodule

// File: rtl/unlock_progress.sv
module unlock_progress
    import unlock_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  unlock_ev_e        ev,
    output logic [STEP_W-1:0] step,
    output logic              fire
);

    logic [STEP_W-1:0] step_d;

    always_comb begin
        case (ev)
            EV_HOLD:    step_d = step;
            EV_ADVANCE: step_d = step + STEP_W'(1);
            EV_RESTART: step_d = STEP_W'(1);
            default:    step_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= '0;
            fire <= 1'b0;
        end else begin
            step <= step_d;
            fire <= (ev == EV_FIRE);
        end
    end

endmodule

// File: rtl/unlock_detector.sv
module unlock_detector
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              acc_stb,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              store_req
);

    logic [STEP_W-1:0] step_q;
    match_t            match;
    unlock_ev_e        ev;

    unlock_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .addr  (acc_addr),
        .step  (step_q),
        .match (match)
    );

    unlock_event_classify u_class (
        .busy  (busy),
        .stb   (acc_stb),
        .wr    (acc_wr),
        .match (match),
        .ev    (ev)
    );

    unlock_progress u_prog (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .step (step_q),
        .fire (store_req)
    );

endmodule

// File: rtl/unlock_detector_chk.sv
module unlock_detector_chk
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              acc_stb,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              store_req,
    input logic [STEP_W-1:0] step_q
);

    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(code_addr(SEQ_LEN-1));

    // R2: a request lasts one cycle
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        store_req |=> !store_req);

    // R2: a request follows a read strobe of the final code address
    p_fire_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(store_req) |-> $past(acc_stb && !acc_wr && acc_addr == LAST_A));

    // R3: no strobe, no request
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !acc_stb |=> !store_req);

    // R4: a write never fires
    p_write_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && acc_wr) |=> (!store_req && step_q == '0));

    // R7: busy clears progress and blocks requests
    p_busy_clear_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!store_req && step_q == '0));

    // R8: progress is zero while a request is out
    p_fire_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        store_req |-> step_q == '0);

    p_step_range_r5: assert property (@(posedge clk) disable iff (rst)
        step_q < STEP_W'(SEQ_LEN));

endmodule

bind unlock_detector unlock_detector_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .acc_stb   (acc_stb),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .store_req (store_req),
    .step_q    (step_q)
);

// File: tb/sim_unlock_detector.sv
module sim_unlock_detector;

    localparam int PERIOD = 10;
    localparam int AW     = 15;

    localparam logic [AW-1:0] A0 = 15'h0E38;
    localparam logic [AW-1:0] A1 = 15'h31C7;
    localparam logic [AW-1:0] A2 = 15'h03E0;
    localparam logic [AW-1:0] A3 = 15'h3C1F;
    localparam logic [AW-1:0] A4 = 15'h303F;
    localparam logic [AW-1:0] A5 = 15'h0FC0;
    localparam logic [AW-1:0] AX = 15'h0E39;

    // vector: {req tag[3:0], busy, stb, wr, addr, expected store_req after edge}
    localparam int VW = 4 + 3 + AW + 1;

    function automatic logic [VW-1:0] rd(input int tag, input logic [AW-1:0] a, input logic e);
        rd = {4'(tag), 1'b0, 1'b1, 1'b0, a, e};
    endfunction
    function automatic logic [VW-1:0] wt(input int tag, input logic [AW-1:0] a);
        wt = {4'(tag), 1'b0, 1'b1, 1'b1, a, 1'b0};
    endfunction
    function automatic logic [VW-1:0] idl(input int tag);
        idl = {4'(tag), 1'b0, 1'b0, 1'b0, AX, 1'b0};
    endfunction
    function automatic logic [VW-1:0] brd(input int tag, input logic [AW-1:0] a);
        brd = {4'(tag), 1'b1, 1'b1, 1'b0, a, 1'b0};
    endfunction

    localparam int NV = 64;
    localparam logic [VW-1:0] VEC [NV] = '{
        // R2 plain code
        rd(2,A0,0), rd(2,A1,0), rd(2,A2,0), rd(2,A3,0), rd(2,A4,0), rd(2,A5,1), idl(2),
        // R3 gaps between steps
        rd(3,A0,0), idl(3), rd(3,A1,0), idl(3), idl(3), rd(3,A2,0), rd(3,A3,0), idl(3),
        rd(3,A4,0), rd(3,A5,1), idl(3),
        // R4 write at step four, then write to the first address
        rd(4,A0,0), rd(4,A1,0), rd(4,A2,0), wt(4,A3), rd(4,A4,0), rd(4,A5,0),
        wt(4,A0), rd(4,A1,0), rd(4,A2,0), rd(4,A3,0), rd(4,A4,0), rd(4,A5,0),
        // R5 near-miss address
        rd(5,A0,0), rd(5,A1,0), rd(5,AX,0), rd(5,A2,0), rd(5,A3,0), rd(5,A4,0), rd(5,A5,0),
        // R6 restart on first address
        rd(6,A0,0), rd(6,A1,0), rd(6,A2,0), rd(6,A0,0), rd(6,A1,0), rd(6,A2,0),
        rd(6,A3,0), rd(6,A4,0), rd(6,A5,1),
        // R9 swapped order
        rd(9,A0,0), rd(9,A1,0), rd(9,A3,0), rd(9,A2,0), rd(9,A4,0), rd(9,A5,0),
        // R7 busy mid-code
        rd(7,A0,0), rd(7,A1,0), rd(7,A2,0), brd(7,A3), rd(7,A4,0), rd(7,A5,0),
        // R8 back-to-back tail after a request
        rd(8,A0,0), rd(8,A1,0), rd(8,A2,0), rd(8,A3,0), rd(8,A4,0), rd(8,A5,1)
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          busy;
    logic          acc_stb;
    logic          acc_wr;
    logic [AW-1:0] acc_addr;
    logic          store_req;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    unlock_detector #(.ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .acc_stb   (acc_stb),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .store_req (store_req)
    );

    task automatic check(input string req, input logic exp);
        n_chk++;
        if (store_req !== exp) begin
            n_fail++;
            $display("FAIL %s: store_req=%b expected=%b at %0t", req, store_req, exp, $time);
        end
    endtask

    // drive at a falling edge, pass one rising edge, sample a quarter period later
    task automatic step(input logic b, input logic s, input logic w, input logic [AW-1:0] a,
                        input logic e, input string req);
        @(negedge clk);
        busy = b; acc_stb = s; acc_wr = w; acc_addr = a;
        @(posedge clk);
        #(PERIOD/4);
        check(req, e);
    endtask

    task automatic code(input logic b, input logic fire_exp, input string req);
        step(b, 1'b1, 1'b0, A0, 1'b0, req);
        step(b, 1'b1, 1'b0, A1, 1'b0, req);
        step(b, 1'b1, 1'b0, A2, 1'b0, req);
        step(b, 1'b1, 1'b0, A3, 1'b0, req);
        step(b, 1'b1, 1'b0, A4, 1'b0, req);
        step(b, 1'b1, 1'b0, A5, fire_exp, req);
    endtask

    initial begin
        rst = 1'b1; busy = 1'b0; acc_stb = 1'b0; acc_wr = 1'b0; acc_addr = '0;
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        check("R1", 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string tg;
            v  = VEC[i];
            tg = $sformatf("R%0d", v[VW-1 -: 4]);
            step(v[AW+3], v[AW+2], v[AW+1], v[AW:1], v[0], tg);
        end

        // R1: reset in the middle of the code
        step(1'b0, 1'b1, 1'b0, A0, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, A1, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, A2, 1'b0, "R1");
        @(negedge clk);
        rst = 1'b1; acc_stb = 1'b0;
        @(posedge clk);
        #(PERIOD/4);
        check("R1", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b1, 1'b0, A3, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, A4, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, A5, 1'b0, "R1");

        // R7: whole code while busy, then a clean code after busy falls
        code(1'b1, 1'b0, "R7");
        code(1'b0, 1'b1, "R7");

        // R6: repeated first address restarts at step two
        step(1'b0, 1'b1, 1'b0, A0, 1'b0, "R6");
        code(1'b0, 1'b1, "R6");

        // R8: after a request, a tail without the first address does nothing
        step(1'b0, 1'b1, 1'b0, A1, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, A2, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, A3, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, A4, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, A5, 1'b0, "R8");

        // R4: write to the final address with the code otherwise complete
        step(1'b0, 1'b1, 1'b0, A0, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, A1, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, A2, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, A3, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, A4, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b1, A5, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, A5, 1'b0, "R4");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule